// File: doc/BRIEF.md
# Third-Order Sinc Decimation Filter

This block turns the one-bit stream of a sigma-delta modulator into 16-bit unsigned conversion words. It takes one modulator bit on every clock and produces one word for every 256 bits. It is built as a cascaded integrator-comb filter of order three. Three integrators run at the modulator rate. Three differentiators run once per decimation period, and each holds a single delay register. The word is offset binary: a ones density of one half sits at mid-scale. A full-scale stream of ones would reach 65536, so that value is clamped to 65535.

Each new word is announced by a one-clock valid strobe, and the word stays on the output until the next strobe. The first two words after reset are built partly from the empty filter history. A settled flag, loaded together with each word, stays low for those two words.

Top module: `sinc3_decimator`

## Requirements
- R1: After reset is released, the first valid strobe appears at the 256th rising clock edge. Every later strobe follows exactly 256 edges after the one before it.
- R2: The valid strobe lasts exactly one clock cycle.
- R3: The word output changes only together with a valid strobe and holds its value between strobes.
- R4: Once settled, a stream whose ones density is k/16 (k from 0 to 15, evenly spread over every 16 bits) gives the code 4096*k. So 0% gives 0 and 50% gives 32768.
- R5: Once settled, a ones density of 13/16 (81.25%) gives 53248 and a density of 3/16 (18.75%) gives 12288.
- R6: A stream of all ones gives 65535 once settled. The word is clamped there and does not wrap to 0.
- R7: While reset is held, the word output is 0 and both the valid strobe and the settled flag are low.
- R8: The settled flag is low with the first and second words after reset and high with every later word. It changes only together with a valid strobe.
- R9: A reset in the middle of a decimation period restarts the period. The next strobe comes 256 edges after release, and the settling sequence of R8 starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; one input bit is taken on each rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator data bit; 1 counts as one and 0 counts as zero |
| word_out | output | 16 | Unsigned offset-binary conversion word |
| word_valid | output | 1 | High for one clock when a new word is loaded |
| word_settled | output | 1 | High when the current word is past the settling interval |

## Verification
A word is loaded at the rising edge that consumes the 256th bit of its period. The bench counts edges from reset release and, at each falling edge, expects the strobe exactly when that count is a multiple of 256. A word's filter window spans about three periods plus the three-edge integrator pipeline. The bench therefore compares a word's value only from the fourth word of each constant-density stretch onward, since only then does the window lie entirely within that stretch. The settled flag and the hold behaviour are checked on every word and every cycle.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    localparam int unsigned ORDER        = 3;
    localparam int unsigned RATIO_LOG2   = 8;
    localparam int unsigned OUT_W        = 16;
    localparam int unsigned RATIO        = 1 << RATIO_LOG2;
    localparam int unsigned ACC_W        = ORDER * RATIO_LOG2 + 1;
    localparam int unsigned SETTLE_WORDS = ORDER - 1;
    localparam int unsigned SEEN_W       = $clog2(SETTLE_WORDS + 1);

    typedef logic [ACC_W-1:0]      acc_t;
    typedef acc_t [ORDER-1:0]      stage_vec_t;
    typedef logic [RATIO_LOG2-1:0] phase_t;
    typedef logic [OUT_W-1:0]      word_t;
    typedef logic [SEEN_W-1:0]     seen_t;
endpackage

// File: rtl/sinc3_integrators.sv
module sinc3_integrators
    import sinc3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output acc_t acc_out
);
    typedef struct packed {
        stage_vec_t acc;
    } integ_state_t;

    integ_state_t st_d, st_q;

    // Each stage adds the previous stage's registered value; wraparound is intended.
    always_comb begin
        st_d = st_q;
        st_d.acc[0] = st_q.acc[0] + {{(ACC_W-1){1'b0}}, bit_in};
        for (int s = 1; s < ORDER; s++) begin
            st_d.acc[s] = st_q.acc[s] + st_q.acc[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_out = st_q.acc[ORDER-1];
endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs
    import sinc3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  acc_t sample_in,
    output acc_t diff_out
);
    typedef struct packed {
        stage_vec_t dly;
    } comb_state_t;

    comb_state_t st_d, st_q;
    logic [ORDER:0][ACC_W-1:0] stage_val;

    assign stage_val[0] = sample_in;

    generate
        for (genvar s = 0; s < ORDER; s++) begin : g_diff
            assign stage_val[s+1] = stage_val[s] - st_q.dly[s];
        end
    endgenerate

    // Delay registers advance only at the decimated rate.
    always_comb begin
        st_d = st_q;
        if (en) begin
            for (int s = 0; s < ORDER; s++) begin
                st_d.dly[s] = stage_val[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign diff_out = stage_val[ORDER];
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_bit,
    output logic [OUT_W-1:0]  word_out,
    output logic              word_valid,
    output logic              word_settled
);
    typedef struct packed {
        phase_t phase;
        word_t  word;
        logic   valid;
        logic   settled;
        seen_t  seen;
    } top_state_t;

    top_state_t st_d, st_q;
    acc_t       integ_out;
    acc_t       comb_out;
    logic       boundary;

    assign boundary = (st_q.phase == '1);

    sinc3_integrators u_integ (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (mod_bit),
        .acc_out (integ_out)
    );

    sinc3_combs u_comb (
        .clk       (clk),
        .rst       (rst),
        .en        (boundary),
        .sample_in (integ_out),
        .diff_out  (comb_out)
    );

    // Top bit set means the result reached full scale: clamp instead of wrapping.
    function automatic word_t clamp_word(acc_t v);
        if (v[ACC_W-1]) return '1;
        return v[ACC_W-2 -: OUT_W];
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + phase_t'(1);
        st_d.valid = 1'b0;
        if (boundary) begin
            st_d.word    = clamp_word(comb_out);
            st_d.valid   = 1'b1;
            st_d.settled = (st_q.seen == seen_t'(SETTLE_WORDS));
            if (st_q.seen != seen_t'(SETTLE_WORDS)) begin
                st_d.seen = st_q.seen + seen_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_out     = st_q.word;
    assign word_valid   = st_q.valid;
    assign word_settled = st_q.settled;
endmodule

// File: rtl/sinc3_decimator_checker.sv
module sinc3_decimator_checker
    import sinc3_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             word_valid,
    input logic [OUT_W-1:0] word_out,
    input logic             word_settled
);
    logic [RATIO_LOG2:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)             gap_q <= '0;
        else if (word_valid) gap_q <= (RATIO_LOG2+1)'(1);
        else                 gap_q <= gap_q + (RATIO_LOG2+1)'(1);
    end

    p_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> gap_q == (RATIO_LOG2+1)'(RATIO));

    p_gap_bound_r1: assert property (@(posedge clk) disable iff (rst)
        gap_q <= (RATIO_LOG2+1)'(RATIO));

    p_one_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_out));

    p_settled_moves_r8: assert property (@(posedge clk) disable iff (rst)
        !word_valid |-> $stable(word_settled));
endmodule

bind sinc3_decimator sinc3_decimator_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .word_valid   (word_valid),
    .word_out     (word_out),
    .word_settled (word_settled)
);

// File: tb/sinc3_decimator_test.sv
module sinc3_decimator_test;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 256;
    localparam int STRETCH    = 8;      // words per constant-density stretch
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        mod_bit;
    logic [15:0] word_out;
    logic        word_valid;
    logic        word_settled;

    int vectors     = 0;
    int miscompares = 0;
    int edges       = 0;
    int fixed_k     = -1;
    int last_word   = 0;
    bit done        = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sinc3_decimator uut (
        .clk          (clk),
        .rst          (rst),
        .mod_bit      (mod_bit),
        .word_out     (word_out),
        .word_valid   (word_valid),
        .word_settled (word_settled)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edges);
        end
    endtask

    function automatic int expect_code(input int k);
        int v;
        v = 4096 * k;
        if (v > 65535) v = 65535;
        return v;
    endfunction

    function automatic string tag_for(input int k);
        if (k == 16) return "R6";
        if (k == 3 || k == 13) return "R5";
        return "R4";
    endfunction

    function automatic int density_at(input int n);
        if (fixed_k >= 0) return fixed_k;
        return n / (PERIOD * STRETCH);
    endfunction

    // One clock: observe the result of the last edge, then drive the next bit.
    task automatic step();
        int g;
        int j;
        int k;
        @(negedge clk);
        edges++;
        check(word_valid == ((edges % PERIOD) == 0), "R1/R2 strobe timing",
              word_valid, (edges % PERIOD) == 0);
        if (word_valid) begin
            g = edges / PERIOD;
            check(word_settled == (g >= 3), "R8 settled flag", word_settled, g >= 3);
            j = (g - 1) % STRETCH + 1;
            k = density_at(edges - 1);
            if (j >= 4)
                check(word_out == expect_code(k), tag_for(k), word_out, expect_code(k));
            last_word = word_out;
        end else begin
            check(word_out == last_word, "R3 hold", word_out, last_word);
        end
        mod_bit = ((edges % 16) < density_at(edges)) ? 1'b1 : 1'b0;
    endtask

    initial begin
        rst     = 1'b1;
        mod_bit = 1'b0;
        repeat (3) @(negedge clk);
        check(word_out == 0,     "R7 word in reset",    word_out, 0);
        check(word_valid == 0,   "R7 valid in reset",   word_valid, 0);
        check(word_settled == 0, "R7 settled in reset", word_settled, 0);
        rst     = 1'b0;
        mod_bit = 1'b0;  // density 0 for the first stretch
        edges   = 0;
        // Sweep of all 17 densities k/16, eight words each.
        for (int c = 0; c < 17 * STRETCH * PERIOD; c++) step();

        // R9: reset in the middle of a period, then an all-ones stream.
        fixed_k = 16;
        for (int c = 0; c < 100; c++) step();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(word_out == 0,     "R7/R9 word after mid reset",    word_out, 0);
        check(word_valid == 0,   "R7/R9 valid after mid reset",   word_valid, 0);
        check(word_settled == 0, "R7/R9 settled after mid reset", word_settled, 0);
        rst       = 1'b0;
        mod_bit   = 1'b1;
        edges     = 0;
        last_word = 0;
        for (int c = 0; c < 6 * PERIOD; c++) step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule